// File: doc/BRIEF.md
# Multihit Channel Time Capture Unit

This block is the per-channel part of a multihit time-to-digital converter. A free-running time counter is shared by all channels and arrives as an input. While the channel is acquiring, every qualifying transition of its sampled input pushes one stamp onto a small last-in-first-out store. Each stamp holds the counter value and a bit that gives the transition's direction. A common strobe latches the reference time and ends acquisition. The channel then unloads its store newest-first. Each word it emits is the reference time minus the stored stamp, so the result needs no pedestal correction.

Each difference is compared with a programmable ceiling that moves in steps of 16 counts. Words above the ceiling are dropped. The store capacity can be programmed, and every emitted word carries a 2-bit count of all qualifying transitions seen during acquisition, including those the full store could not keep. A channel that recorded nothing emits no words.

The control is a two-state machine. `S_ACQ` (acquire) leaves on the transition `acq_to_read`, taken when `common_stb` is high. `S_READ` (read out) pops one stamp per cycle and leaves on the transition `read_to_acq`, taken in the first cycle that finds the store empty. That transition also clears the hit count.

Top module: `mhit_chan_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `out_valid` and `busy` are 0.
- R2: `cfg_edge_sel` selects which transitions are recorded: 2'b01 records rising transitions only, 2'b10 falling only, 2'b11 both, and 2'b00 none.
- R3: `out_edge` is 0 for a word from a rising transition and 1 for a word from a falling one.
- R4: Words leave newest-first, and `out_diff` equals (reference time − stamp) modulo 2^16. The stamp is the `time_cnt` value in the cycle the transition is first seen, and the reference is the `time_cnt` value in the cycle `common_stb` is seen.
- R5: A word is emitted (`out_valid`=1) only if `out_diff` <= `cfg_thresh`×16. Any other popped stamp is dropped.
- R6: The store keeps at most `cfg_depth` stamps, where 0 or any value above 16 means 16. Qualifying transitions that arrive while the store is full are not stored.
- R7: `out_hits` equals the number of qualifying transitions in the acquisition, modulo 4, including those not stored.
- R8: A channel with no stored stamps emits no word. Its `busy` stays high for exactly one cycle.
- R9: `busy` rises in the cycle after `common_stb` is seen. Popped stamps appear on consecutive cycles from that cycle onward, and `busy` falls one cycle after the last pop.
- R10: Transitions and strobes that occur while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_cnt | input | 16 | Shared free-running time counter |
| chan_in | input | 1 | Sampled channel signal |
| common_stb | input | 1 | Common strobe: latches reference time, starts readout |
| cfg_edge_sel | input | 2 | Transition selection (R2 codes) |
| cfg_depth | input | 5 | Store capacity, 0 means 16 |
| cfg_thresh | input | 12 | Ceiling in units of 16 counts |
| out_valid | output | 1 | Difference word valid |
| out_diff | output | 16 | Reference minus stamp |
| out_edge | output | 1 | Direction of the stamped transition |
| out_hits | output | 2 | Qualifying transitions modulo 4 |
| busy | output | 1 | Readout in progress |

## Verification
Trains of pulses are sent in each transition mode. Comparing the words that come out tells apart a wrong edge filter, a wrong direction bit and a FIFO-order mistake. A store capped at two with ten transitions separates the stored count from the wrapped hit count. A ceiling of 16 counts, with one old and one recent stamp, shows whether the comparison is made on the difference and at the right scale. A run straddling the counter wrap, pulses during readout, and a strobe that coincides with a transition check the modulo subtraction, the ignore rule and the same-cycle ordering.

// File: rtl/mhit_pkg.sv
package mhit_pkg;
    typedef enum logic {
        S_ACQ  = 1'b0,
        S_READ = 1'b1
    } rd_state_t;

    localparam logic [1:0] EDGE_NONE = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;
endpackage

// File: rtl/mhit_edge_det.sv
module mhit_edge_det (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig,
    input  logic       enable,
    input  logic [1:0] sel,
    output logic       hit,
    output logic       is_fall
);
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    always_comb begin
        rise    = sig & ~prev_q;
        fall    = ~sig & prev_q;
        hit     = enable & ((rise & sel[0]) | (fall & sel[1]));
        is_fall = fall;
    end

    // R2: nothing qualifies when no direction is selected
    a_r2_none_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == mhit_pkg::EDGE_NONE) |-> !hit);
endmodule

// File: rtl/mhit_lifo.sv
module mhit_lifo #(
    parameter int W     = 17,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic [CW-1:0] cap,
    output logic [W-1:0]  top,
    output logic [CW-1:0] count,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_m1;
    logic          do_push;

    always_comb begin
        do_push = push && (cnt_q < cap);
        cnt_m1  = cnt_q - 1'b1;
        top     = mem[cnt_m1[AW-1:0]];
        count   = cnt_q;
        empty   = (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (do_push)          cnt_q <= cnt_q + 1'b1;
        else if (pop && !empty)    cnt_q <= cnt_m1;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[cnt_q[AW-1:0]] <= din;
    end

    // R6: a push into a full store leaves the occupancy unchanged
    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && cnt_q >= cap) |=> (cnt_q == $past(cnt_q)));
    // R4: each pop removes exactly one entry
    a_r4_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mhit_diff_chk.sv
module mhit_diff_chk #(
    parameter int TW        = 16,
    parameter int STEP_BITS = 4
) (
    input  logic [TW-1:0]           ref_t,
    input  logic [TW-1:0]           stamp,
    input  logic [TW-STEP_BITS-1:0] thr,
    output logic [TW-1:0]           diff,
    output logic                    keep
);
    logic [TW-1:0] limit;

    always_comb begin
        diff  = ref_t - stamp;
        limit = {thr, {STEP_BITS{1'b0}}};
        keep  = (diff <= limit);
    end
endmodule

// File: rtl/mhit_chan_top.sv
module mhit_chan_top #(
    parameter int TW        = 16,
    parameter int DEPTH     = 16,
    parameter int STEP_BITS = 4,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int THW      = TW - STEP_BITS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  time_cnt,
    input  logic           chan_in,
    input  logic           common_stb,
    input  logic [1:0]     cfg_edge_sel,
    input  logic [CW-1:0]  cfg_depth,
    input  logic [THW-1:0] cfg_thresh,
    output logic           out_valid,
    output logic [TW-1:0]  out_diff,
    output logic           out_edge,
    output logic [1:0]     out_hits,
    output logic           busy
);
    import mhit_pkg::*;

    rd_state_t     state_q, state_d;
    logic [TW-1:0] ref_q;
    logic [1:0]    hits_q;
    logic [CW-1:0] cap;
    logic          hit, is_fall, pop;
    logic [TW:0]   top;
    logic [CW-1:0] count;
    logic          empty;
    logic [TW-1:0] diff;
    logic          keep;

    mhit_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .sig(chan_in),
        .enable(state_q == S_ACQ), .sel(cfg_edge_sel),
        .hit(hit), .is_fall(is_fall)
    );

    mhit_lifo #(.W(TW + 1), .DEPTH(DEPTH)) u_lifo (
        .clk(clk), .rst_n(rst_n), .push(hit), .din({is_fall, time_cnt}),
        .pop(pop), .cap(cap), .top(top), .count(count), .empty(empty)
    );

    mhit_diff_chk #(.TW(TW), .STEP_BITS(STEP_BITS)) u_diff (
        .ref_t(ref_q), .stamp(top[TW-1:0]), .thr(cfg_thresh),
        .diff(diff), .keep(keep)
    );

    always_comb begin
        cap = (cfg_depth == '0 || cfg_depth > CW'(DEPTH)) ? CW'(DEPTH) : cfg_depth;
        pop = (state_q == S_READ) && !empty;
        busy = (state_q == S_READ);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ACQ:  if (common_stb) state_d = S_READ;   // acq_to_read
            S_READ: if (empty)      state_d = S_ACQ;    // read_to_acq
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_ACQ;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q     <= '0;
            hits_q    <= '0;
            out_valid <= 1'b0;
            out_diff  <= '0;
            out_edge  <= 1'b0;
            out_hits  <= '0;
        end else begin
            out_valid <= pop && keep;
            unique case (state_q)
                S_ACQ: begin
                    if (hit)        hits_q <= hits_q + 1'b1;
                    if (common_stb) ref_q  <= time_cnt;
                end
                S_READ: begin
                    if (pop) begin
                        out_diff <= diff;
                        out_edge <= top[TW];
                        out_hits <= hits_q;
                    end else begin
                        hits_q <= '0;
                    end
                end
            endcase
        end
    end

    // R9: a strobe during acquisition starts readout on the next cycle
    a_r9_busy_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACQ && common_stb) |=> busy);
    // R8: a word only follows a readout cycle
    a_r8_word_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy));
    // R10: the store never grows during readout
    a_r10_no_push_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (count <= $past(count)));
    // R5: no emitted word exceeds the ceiling in force when it was popped
    a_r5_under_limit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_diff <= {$past(cfg_thresh), {STEP_BITS{1'b0}}}));
endmodule

// File: tb/mhit_chan_top_bench.sv
module mhit_chan_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] time_cnt = 16'd0;
    logic        chan_in = 1'b0;
    logic        common_stb = 1'b0;
    logic [1:0]  cfg_edge_sel = 2'b11;
    logic [4:0]  cfg_depth = 5'd0;
    logic [11:0] cfg_thresh = 12'hFFF;
    logic        out_valid;
    logic [15:0] out_diff;
    logic        out_edge;
    logic [1:0]  out_hits;
    logic        busy;

    mhit_chan_top u_mhit_chan_top (
        .clk(clk), .rst_n(rst_n), .time_cnt(time_cnt), .chan_in(chan_in),
        .common_stb(common_stb), .cfg_edge_sel(cfg_edge_sel),
        .cfg_depth(cfg_depth), .cfg_thresh(cfg_thresh),
        .out_valid(out_valid), .out_diff(out_diff), .out_edge(out_edge),
        .out_hits(out_hits), .busy(busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int words = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    // behavioural reference model
    int q[$];
    bit m_rd, m_prev, e_valid, e_edge, rise, fall;
    int m_hits, m_ref, e_diff, e_hits, cap_i, s, d;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) time_cnt <= time_cnt + 16'd1;

    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_rd = 0; q.delete(); m_hits = 0; m_prev = 0; e_valid = 0;
        end else begin
            cap_i = (cfg_depth == 0 || cfg_depth > 16) ? 16 : int'(cfg_depth);
            if (!m_rd) begin
                rise = chan_in && !m_prev;
                fall = !chan_in && m_prev;
                if ((rise && cfg_edge_sel[0]) || (fall && cfg_edge_sel[1])) begin
                    m_hits = (m_hits + 1) % 4;
                    if (q.size() < cap_i) q.push_back((int'(fall) << 16) | int'(time_cnt));
                end
                if (common_stb) begin m_rd = 1; m_ref = int'(time_cnt); end
                e_valid = 0;
            end else if (q.size() > 0) begin
                s = q.pop_back();
                d = (m_ref - (s & 'hFFFF)) & 'hFFFF;
                e_valid = (d <= int'(cfg_thresh) * 16);
                e_diff = d; e_edge = bit'(s >> 16); e_hits = m_hits;
            end else begin
                m_rd = 0; m_hits = 0; e_valid = 0;
            end
            m_prev = chan_in;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            if (!rst_n) begin
                chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
                chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
            end else begin
                chk(busy == m_rd, "R9 busy", int'(busy), int'(m_rd));
                chk(out_valid == e_valid, "R5 valid", int'(out_valid), int'(e_valid));
                if (out_valid && e_valid) begin
                    chk(int'(out_diff) == e_diff, "R4 diff", int'(out_diff), e_diff);
                    chk(out_edge == e_edge, "R3 edge", int'(out_edge), int'(e_edge));
                    chk(int'(out_hits) == e_hits, "R7 hits", int'(out_hits), e_hits);
                end
                if (out_valid) words++;
            end
        end
    end

    task automatic pulse(input int w, input int gap);
        @(negedge clk) chan_in = 1'b1;
        repeat (w) @(negedge clk);
        chan_in = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic strobe_and_count(input int exp_words, input string tag);
        @(negedge clk) common_stb = 1'b1;
        @(negedge clk) common_stb = 1'b0;
        repeat (24) @(negedge clk);
        chk(words == exp_words, tag, words, exp_words);
        words = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && busy == 1'b0, "R1 after reset", int'(busy), 0);
        words = 0;

        // both directions, full ceiling: six words
        cfg_edge_sel = 2'b11;
        for (int i = 0; i < 3; i++) pulse(2 + i, 3);
        strobe_and_count(6, "R2 both count");

        // rising only
        cfg_edge_sel = 2'b01;
        for (int i = 0; i < 3; i++) pulse(3, 2);
        strobe_and_count(3, "R2 rise count");

        // falling only
        cfg_edge_sel = 2'b10;
        for (int i = 0; i < 2; i++) pulse(4, 2);
        strobe_and_count(2, "R3 fall count");

        // none selected: zero suppression
        cfg_edge_sel = 2'b00;
        for (int i = 0; i < 2; i++) pulse(2, 2);
        strobe_and_count(0, "R8 empty channel");

        // capacity two, ten transitions, hits wrap to 2
        cfg_edge_sel = 2'b11;
        cfg_depth = 5'd2;
        for (int i = 0; i < 5; i++) pulse(2, 2);
        strobe_and_count(2, "R6 capped count");
        cfg_depth = 5'd0;

        // pulse during readout is ignored
        pulse(2, 2);
        @(negedge clk) common_stb = 1'b1;
        @(negedge clk) begin common_stb = 1'b0; chan_in = 1'b1; end
        @(negedge clk) chan_in = 1'b0;
        repeat (24) @(negedge clk);
        chk(words == 2, "R10 ignored during busy", words, 2);
        words = 0;

        // ceiling of 16 counts: old stamp dropped, recent kept
        cfg_edge_sel = 2'b01;
        cfg_thresh = 12'd1;
        pulse(2, 30);
        pulse(2, 3);
        strobe_and_count(1, "R5 threshold count");
        cfg_thresh = 12'hFFF;

        // counter wrap
        cfg_edge_sel = 2'b11;
        @(negedge clk) time_cnt = 16'hFFF8;
        pulse(3, 6);
        strobe_and_count(2, "R4 wrap count");

        // transition and strobe in the same cycle
        cfg_edge_sel = 2'b01;
        @(negedge clk) begin chan_in = 1'b1; common_stb = 1'b1; end
        @(negedge clk) common_stb = 1'b0;
        @(negedge clk) chan_in = 1'b0;
        repeat (24) @(negedge clk);
        chk(words == 1, "R9 same-cycle strobe", words, 1);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end
endmodule